// File: doc/BRIEF.md
# Memory Clock Source Switcher

This block moves the memory clock from one source and divider to another when a new frequency code arrives. A requester presents a frequency value (in MHz) with a one-cycle start strobe. The block turns a frequency it knows into a source/divider pair. It gates the memory clock off and waits for the clock-generation control word to stop reporting a write lock. It then writes the new setting and waits for that word to report that the switch is complete. Finally it ungates the clock, waits once more for the lock to clear, and signals completion with a one-cycle done pulse.

The clock generator itself is outside the block. Its control word is seen as a 32-bit read value that carries a lock flag and a switch-complete flag, and the block writes that word over a simple write strobe with data. A frequency the block does not know still produces a gate-off/gate-on cycle, but no write. Every wait is bounded by a timeout. When a timeout expires, an error flag is raised and the sequence moves on, so the clock is never left gated.

Top module: `dclk_switch`

## Requirements
- R1: The clock gate output is low during every cycle in which a control-word write is issued. It is high whenever the block is idle and in the cycle of the done pulse. Each accepted request holds it low for at least one cycle.
- R2: No control-word write is issued while the lock flag (bit 31 of the read word) is set.
- R3: The written control word carries the source select in bits 30:28 and the divider in bits 23:21, with all other bits zero. A request for a known frequency produces exactly one write.
- R4: After a write, the clock gate stays low until the switch-complete flag (bit 27 of the read word) has been observed set.
- R5: The frequency codes map as follows: 384 gives source 0 divider 0; 192 gives source 0 divider 1; 48 gives source 2 divider 0; 528 gives source 4 divider 1; 264 gives source 4 divider 3.
- R6: Any other frequency code produces no write, but the clock gate still goes low and then returns high before done.
- R7: After the clock is ungated, done is raised only once the lock flag has been seen clear. This applies unless that wait timed out.
- R8: A start strobe while busy is ignored. Done is high for exactly one cycle per accepted request. Busy is high from the cycle after an accepted start through the done cycle, and low afterwards.
- R9: A wait that sees no wanted flag for TIMEOUT_CYCLES consecutive cycles sets the error flag. A timeout in one of the two waits before ungating goes straight to ungating the clock, and a timeout in the final wait goes straight to done. The error flag holds until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| freq_i | input | FREQ_W | Requested frequency code in MHz |
| cg_rd_i | input | 32 | Clock-generation control word read value (bit 31 lock, bit 27 switch complete) |
| cg_wr_en_o | output | 1 | Control word write strobe |
| cg_wr_data_o | output | 32 | Control word write data |
| clk_gate_en_o | output | 1 | Memory clock enable (low gates the clock off) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | A wait timed out during the last request |

## Verification
The bench builds the block with FREQ_W = 10 and TIMEOUT_CYCLES = 6. The 10-bit width lets it sweep every frequency code from 0 to 1023, so all five known codes and every unknown code go through the full sequence. Lock and switch-complete latencies vary from request to request. The short timeout lets a stuck lock, a missing switch-complete flag and an overlong final lock each be forced in a few cycles. A lock released in the last allowed cycle of the wait, and one released a cycle later, probe the exact timeout boundary.

// File: rtl/dclk_switch_pkg.sv
package dclk_switch_pkg;

  localparam int CW_W       = 32;
  localparam int LOCK_BIT   = 31;
  localparam int SWDONE_BIT = 27;
  localparam int SRC_LSB    = 28;
  localparam int DIV_LSB    = 21;
  localparam int FIELD_W    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOFF,
    ST_UNLK1,
    ST_WR,
    ST_SWT,
    ST_GON,
    ST_UNLK2,
    ST_FIN
  } dclk_state_e;

  typedef struct packed {
    logic               hit;
    logic [FIELD_W-1:0] src;
    logic [FIELD_W-1:0] div;
  } dclk_sel_t;

endpackage

// File: rtl/dclk_freq_map.sv
module dclk_freq_map
  import dclk_switch_pkg::*;
#(
  parameter int FREQ_W = 10
) (
  input  logic [FREQ_W-1:0] freq_i,
  output dclk_sel_t         sel_o
);

  always_comb begin
    sel_o = '0;
    case (freq_i)
      FREQ_W'(48):  begin sel_o.hit = 1'b1; sel_o.src = 3'd2; sel_o.div = 3'd0; end
      FREQ_W'(192): begin sel_o.hit = 1'b1; sel_o.src = 3'd0; sel_o.div = 3'd1; end
      FREQ_W'(384): begin sel_o.hit = 1'b1; sel_o.src = 3'd0; sel_o.div = 3'd0; end
      FREQ_W'(264): begin sel_o.hit = 1'b1; sel_o.src = 3'd4; sel_o.div = 3'd3; end
      FREQ_W'(528): begin sel_o.hit = 1'b1; sel_o.src = 3'd4; sel_o.div = 3'd1; end
      default:      sel_o = '0;
    endcase
  end

endmodule

// File: rtl/dclk_wait_timer.sv
module dclk_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | run_i;
    cnt_d  = clr_i ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = run_i & (cnt_q == LAST);

endmodule

// File: rtl/dclk_seq.sv
module dclk_seq
  import dclk_switch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  dclk_sel_t        sel_i,
  input  logic             lock_i,
  input  logic             swdone_i,
  input  logic             expire_i,
  output logic             run_o,
  output logic             clr_o,
  output logic             wr_en_o,
  output logic [CW_W-1:0]  wr_data_o,
  output logic             gate_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  dclk_state_e state_q, state_d;
  dclk_sel_t   sel_q;
  logic        err_q, err_d;
  logic        accept, set_err;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    set_err = 1'b0;
    case (state_q)
      ST_IDLE:  if (start_i) begin state_d = ST_GOFF; accept = 1'b1; end
      ST_GOFF:  state_d = sel_q.hit ? ST_UNLK1 : ST_GON;
      ST_UNLK1: begin
        if (!lock_i)       state_d = ST_WR;
        else if (expire_i) begin state_d = ST_GON; set_err = 1'b1; end
      end
      ST_WR:    state_d = ST_SWT;
      ST_SWT: begin
        if (swdone_i)      state_d = ST_GON;
        else if (expire_i) begin state_d = ST_GON; set_err = 1'b1; end
      end
      ST_GON:   state_d = ST_UNLK2;
      ST_UNLK2: begin
        if (!lock_i)       state_d = ST_FIN;
        else if (expire_i) begin state_d = ST_FIN; set_err = 1'b1; end
      end
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    err_d = accept ? 1'b0 : (set_err ? 1'b1 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (accept) sel_q <= sel_i;
  end

  always_comb begin
    run_o     = (state_q == ST_UNLK1) | (state_q == ST_SWT) | (state_q == ST_UNLK2);
    clr_o     = (state_d != state_q);
    wr_en_o   = (state_q == ST_WR);
    gate_en_o = !((state_q == ST_GOFF) | (state_q == ST_UNLK1) |
                  (state_q == ST_WR)   | (state_q == ST_SWT));
    busy_o    = (state_q != ST_IDLE);
    done_o    = (state_q == ST_FIN);
    err_o     = err_q;
    wr_data_o = '0;
    wr_data_o[SRC_LSB +: FIELD_W] = sel_q.src;
    wr_data_o[DIV_LSB +: FIELD_W] = sel_q.div;
  end

endmodule

// File: rtl/dclk_switch.sv
module dclk_switch
  import dclk_switch_pkg::*;
#(
  parameter int FREQ_W         = 10,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [31:0]       cg_rd_i,
  output logic              cg_wr_en_o,
  output logic [31:0]       cg_wr_data_o,
  output logic              clk_gate_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  dclk_sel_t sel;
  logic      run, clr, expire;

  dclk_freq_map #(.FREQ_W(FREQ_W)) u_map (
    .freq_i (freq_i),
    .sel_o  (sel)
  );

  dclk_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .run_i    (run),
    .expire_o (expire)
  );

  dclk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sel_i     (sel),
    .lock_i    (cg_rd_i[LOCK_BIT]),
    .swdone_i  (cg_rd_i[SWDONE_BIT]),
    .expire_i  (expire),
    .run_o     (run),
    .clr_o     (clr),
    .wr_en_o   (cg_wr_en_o),
    .wr_data_o (cg_wr_data_o),
    .gate_en_o (clk_gate_en_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

endmodule

// File: rtl/dclk_switch_chk.sv
module dclk_switch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] cg_rd_i,
  input logic        cg_wr_en_o,
  input logic [31:0] cg_wr_data_o,
  input logic        clk_gate_en_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);

  localparam logic [31:0] FIELD_MASK = (32'h7 << 28) | (32'h7 << 21);

  // R1
  gate_off_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cg_wr_en_o |-> !clk_gate_en_o);

  // R1
  gate_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> clk_gate_en_o);

  // R2
  no_wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cg_wr_en_o |-> !cg_rd_i[31]);

  // R3
  wr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cg_wr_en_o |-> ((cg_wr_data_o & ~FIELD_MASK) == 32'h0));

  // R7
  done_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_o) && !err_o) |-> !$past(cg_rd_i[31]));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  // R9
  err_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> busy_o);

endmodule

bind dclk_switch dclk_switch_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .cg_rd_i       (cg_rd_i),
  .cg_wr_en_o    (cg_wr_en_o),
  .cg_wr_data_o  (cg_wr_data_o),
  .clk_gate_en_o (clk_gate_en_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/dclk_switch_test.sv
module dclk_switch_test;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 10;
  localparam int TMO = 6;

  logic          clk, rst_n, start_i;
  logic [FW-1:0] freq_i;
  logic [31:0]   cg_rd_i, cg_wr_data_o;
  logic          cg_wr_en_o, clk_gate_en_o, busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;

  int  cyc, pre_until, post_until, sw_at;
  int  post_lock, sw_lat;
  logic stuck_lock, stuck_sw, sw_bit, gate_q, lock;

  dclk_switch #(.FREQ_W(FW), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freq_i(freq_i),
    .cg_rd_i(cg_rd_i), .cg_wr_en_o(cg_wr_en_o), .cg_wr_data_o(cg_wr_data_o),
    .clk_gate_en_o(clk_gate_en_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // clock-generation register model
  always_comb begin
    lock    = stuck_lock || (cyc < pre_until) || (cyc < post_until);
    cg_rd_i = {lock, 3'b000, sw_bit, 27'h0};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; gate_q <= 1'b1; post_until <= 0; sw_bit <= 1'b1; sw_at <= 0;
    end else begin
      cyc    <= cyc + 1;
      gate_q <= clk_gate_en_o;
      if (clk_gate_en_o && !gate_q) post_until <= cyc + 1 + post_lock;
      if (cg_wr_en_o) begin
        sw_bit <= 1'b0;
        sw_at  <= cyc + 1 + sw_lat;
      end else if (!stuck_sw && cyc >= sw_at) begin
        sw_bit <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input int f);
    return (f == 48) || (f == 192) || (f == 384) || (f == 264) || (f == 528);
  endfunction

  function automatic longint exp_word(input int f);
    int s, d;
    s = 0; d = 0;
    if (f == 48)  begin s = 2; d = 0; end
    if (f == 192) begin s = 0; d = 1; end
    if (f == 384) begin s = 0; d = 0; end
    if (f == 264) begin s = 4; d = 3; end
    if (f == 528) begin s = 4; d = 1; end
    return (longint'(s) << 28) | (longint'(d) << 21);
  endfunction

  task automatic run_req(input int f, input int pre, input int lat, input int post,
                         input int exp_w, input bit exp_e, input bit mid_start);
    int wr_cnt, gate_low, done_cnt, wr_gate_on, wr_locked, early_gate;
    bit seen_done, wr_seen, sw_seen, done_gate, done_lock, done_err;
    longint data;
    wr_cnt = 0; gate_low = 0; done_cnt = 0; wr_gate_on = 0; wr_locked = 0;
    early_gate = 0; seen_done = 0; wr_seen = 0; sw_seen = 0;
    done_gate = 0; done_lock = 0; done_err = 0; data = 0;
    post_lock = post; sw_lat = lat;
    pre_until = cyc + pre + 1;
    start_i = 1'b1; freq_i = FW'(f);
    for (int i = 0; i < 120 && !seen_done; i++) begin
      @(negedge clk);
      start_i = (mid_start && i == 2) ? 1'b1 : 1'b0;
      if (mid_start && i == 2) freq_i = FW'(528);
      if (!clk_gate_en_o) gate_low++;
      if (wr_seen && !sw_seen && clk_gate_en_o && !stuck_sw) early_gate++;
      if (wr_seen && cg_rd_i[27]) sw_seen = 1;
      if (cg_wr_en_o) begin
        wr_cnt++; data = longint'(cg_wr_data_o); wr_seen = 1;
        if (clk_gate_en_o) wr_gate_on++;
        if (lock) wr_locked++;
      end
      if (done_o) begin
        done_cnt++; seen_done = 1;
        done_gate = clk_gate_en_o; done_lock = lock; done_err = err_o;
      end
    end
    chk(seen_done, "R8 done reached", seen_done, 1);
    chk(wr_cnt == exp_w, exp_w ? "R3 write count" : "R6 write count", wr_cnt, exp_w);
    if (exp_w == 1 && wr_cnt == 1) chk(data == exp_word(f), "R5 word", data, exp_word(f));
    chk(gate_low >= 1, exp_w ? "R1 gate low" : "R6 gate low", gate_low, 1);
    chk(done_gate, "R1 gate on at done", done_gate, 1);
    chk(wr_gate_on == 0, "R1 write gated", wr_gate_on, 0);
    chk(wr_locked == 0, "R2 write locked", wr_locked, 0);
    chk(early_gate == 0, "R4 early ungate", early_gate, 0);
    if (!exp_e) chk(!done_lock, "R7 done unlocked", done_lock, 0);
    chk(done_err == exp_e, "R9 err flag", done_err, exp_e);
    @(negedge clk);
    chk(!done_o && !busy_o, "R8 single done", {done_o, busy_o}, 0);
    chk(clk_gate_en_o, "R1 gate idle", clk_gate_en_o, 1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; freq_i = '0;
    stuck_lock = 1'b0; stuck_sw = 1'b0; post_lock = 0; sw_lat = 0; pre_until = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !cg_wr_en_o && clk_gate_en_o,
        "R1 R8 reset state", {busy_o, done_o, err_o, cg_wr_en_o, clk_gate_en_o}, 1);

    // sweep of every frequency code with varied latencies (R5, R6)
    for (int f = 0; f < (1 << FW); f++)
      run_req(f, f % 4, f % 5, f % 3, exp_hit(f) ? 1 : 0, 1'b0, 1'b0);

    // start strobe while busy ignored (R8)
    run_req(48, 2, 3, 1, 1, 1'b0, 1'b1);
    run_req(77, 0, 0, 2, 0, 1'b0, 1'b1);

    // timeout boundary on the pre-write lock wait (R9)
    run_req(384, 6, 1, 0, 1, 1'b0, 1'b0);
    run_req(384, 7, 1, 0, 0, 1'b1, 1'b0);

    // stuck lock: both lock waits time out (R9)
    stuck_lock = 1'b1;
    run_req(264, 0, 0, 0, 0, 1'b1, 1'b0);
    stuck_lock = 1'b0;
    run_req(264, 0, 0, 0, 1, 1'b0, 1'b0);

    // switch-complete never arrives (R9)
    stuck_sw = 1'b1;
    run_req(192, 0, 0, 0, 1, 1'b1, 1'b0);
    stuck_sw = 1'b0;

    // overlong lock after ungating (R9), then error cleared
    run_req(528, 0, 2, 20, 1, 1'b1, 1'b0);
    repeat (25) @(negedge clk);
    run_req(528, 1, 2, 1, 1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule